// File: doc/BRIEF.md
# Local Access Window Address Decoder

This block sorts every 32-bit address issued by a processor or a DMA engine into one of thirteen target interfaces. Each target has its own local access window. The block holds the registers that place these windows, and software loads them through a simple indexed write port. For each valid request the block registers a one-hot target select, a hit flag, an error flag and a multi-hit flag, and passes the address through unchanged. All of these appear one cycle after the request.

Three window encodings sit side by side in the block:

- **Fixed-size windows with a base only:** the configuration window (1 MB), the SRAM window and the NAND flash window (1 MB).
- **Inclusive start/stop page ranges:** nine windows, one for the boot chip select and one for each of chip selects 0 to 7.
- **Base plus power-of-two size:** one window for the DDR controller.

The SRAM window reserves 256 KB, but only the first 32 KB is backed by memory. An access that lands in the reserved tail of the SRAM window gets an error response instead of a hit. When two or more windows overlap, the lowest-numbered window wins.

Top module: `addr_window_decoder`

## Requirements
- R1: Select bit k of `tgt_sel` stands for window k (0 configuration, 1 to 9 range windows, 10 DDR, 11 SRAM, 12 NAND). At most one bit is set. The results for an access presented in one cycle appear after the next rising clock edge, with `out_valid` high.
- R2: `addr_out` is equal to the address of the access, one cycle later.
- R3: Window 0 is always enabled. It covers the 1 MB block whose address bits [31:20] equal bits [31:20] of register index 0. That register resets to `CFG_RESET_BASE`, which defaults to 0xFF40_0000.
- R4: Range window k (k = 1 to 9) has two registers. Its start is at index k, with bit 0 as the enable. Its stop is at index 16+k. The window hits when the enable is set and start[31:12] ≤ addr[31:12] ≤ stop[31:12]. Both bounds are inclusive at 4 KB page granularity.
- R5: Window 10 takes its base from index 10 and its attributes from index 26. In the attribute register, bit 31 is the enable and bits [4:0] hold n, which gives a size of 2^(n+1) bytes. The window hits when the address and the base agree in bits [31:n+1]. A value of n outside 11 to 30 disables the window.
- R6: Window 11 has its register at index 49, which is byte offset 0xC4 divided by 4. Bit 0 is the enable and bits [31:18] give a 256 KB aligned base. An address in the first 32 KB of that region is a hit on window 11.
- R7: An address in the SRAM region at or above 32 KB, with no lower-numbered window hitting, gives `err`=1, `hit`=0 and `tgt_sel`=0.
- R8: Window 12 has its register at index 50, which is byte offset 0xC8 divided by 4. Bit 0 is the enable. The window covers the 1 MB block whose address bits [31:20] match bits [31:20] of that register.
- R9: When several windows cover an address, the lowest-numbered window is selected. `multi_hit` is 1 when two or more windows cover the address, and the SRAM reserved tail counts as covered.
- R10: An address that no window covers gives `hit`=0, `err`=0 and `tgt_sel`=0.
- R11: After reset, every window except window 0 is disabled and all outputs are 0. A register write on one clock edge governs the decode of an access presented in the following cycle. An access presented in the same cycle as the write still sees the old value.
- R12: When `req_valid` is low, the next cycle shows `out_valid`, `hit`, `err`, `multi_hit` and `tgt_sel` all at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 6 | Register index to write |
| wr_data | input | 32 | Register write data |
| req_valid | input | 1 | Access request valid |
| addr_in | input | 32 | Access address |
| out_valid | output | 1 | Decode result valid |
| addr_out | output | 32 | Untranslated address |
| tgt_sel | output | 13 | One-hot target select |
| hit | output | 1 | Access decoded to a target |
| err | output | 1 | Access fell in the SRAM reserved tail |
| multi_hit | output | 1 | Two or more windows covered the access |

## Verification
The bench builds the block with its default parameters:

- 4 KB page granularity.
- A 1 MB configuration window at 0xFF40_0000.
- 32 KB of populated SRAM inside a 256 KB reservation.
- A 1 MB NAND window.

With these values, every page edge of a range window, the 32 KB populated boundary and the 256 KB region edge can be reached in a few directed accesses. The directed cases also include:

- A write in the same cycle as an access, to check the old value is used.
- DDR sizes of 256 MB and 2 GB.
- A DDR size that is out of range.
- Overlaps that exercise priority.

Seeded random writes to the register file are then mixed with accesses aimed near the programmed bases.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int AW   = 32;
  localparam int NWIN = 13;
  localparam int NRNG = 9;
  localparam int IDXW = 6;

  localparam int W_CFG  = 0;
  localparam int W_DDR  = 10;
  localparam int W_SRAM = 11;
  localparam int W_NAND = 12;

  localparam logic [IDXW-1:0] IDX_CFG      = 6'd0;
  localparam logic [IDXW-1:0] IDX_START0   = 6'd1;
  localparam logic [IDXW-1:0] IDX_STOP0    = 6'd17;
  localparam logic [IDXW-1:0] IDX_DDR_BASE = 6'd10;
  localparam logic [IDXW-1:0] IDX_DDR_ATTR = 6'd26;
  localparam logic [IDXW-1:0] IDX_SRAM     = 6'd49;
  localparam logic [IDXW-1:0] IDX_NAND     = 6'd50;

  localparam int DDR_N_MIN = 11;
  localparam int DDR_N_MAX = 30;

  // ones in every bit at or above lsb
  function automatic logic [AW-1:0] hi_mask(input int lsb);
    logic [AW:0] m;
    m = {(AW+1){1'b1}} << lsb;
    return m[AW-1:0];
  endfunction
endpackage

// File: rtl/awd_regs.sv
module awd_regs
  import awd_pkg::*;
#(
  parameter logic [AW-1:0] CFG_RESET_BASE = 32'hFF40_0000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [IDXW-1:0]           wr_idx,
  input  logic [AW-1:0]             wr_data,
  output logic [AW-1:0]             cfg_base,
  output logic [NRNG-1:0][AW-1:0]   rng_start,
  output logic [NRNG-1:0][AW-1:0]   rng_stop,
  output logic [AW-1:0]             ddr_base,
  output logic [AW-1:0]             ddr_attr,
  output logic [AW-1:0]             sram_base,
  output logic [AW-1:0]             nand_base
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_base  <= CFG_RESET_BASE;
      rng_start <= '0;
      rng_stop  <= '0;
      ddr_base  <= '0;
      ddr_attr  <= '0;
      sram_base <= '0;
      nand_base <= '0;
    end else if (wr_en) begin
      if (wr_idx == IDX_CFG)      cfg_base  <= wr_data;
      if (wr_idx == IDX_DDR_BASE) ddr_base  <= wr_data;
      if (wr_idx == IDX_DDR_ATTR) ddr_attr  <= wr_data;
      if (wr_idx == IDX_SRAM)     sram_base <= wr_data;
      if (wr_idx == IDX_NAND)     nand_base <= wr_data;
      for (int k = 0; k < NRNG; k++) begin
        if (wr_idx == IDX_START0 + IDXW'(k)) rng_start[k] <= wr_data;
        if (wr_idx == IDX_STOP0 + IDXW'(k))  rng_stop[k]  <= wr_data;
      end
    end
  end
endmodule

// File: rtl/awd_match.sv
module awd_match
  import awd_pkg::*;
#(
  parameter int PAGE_LOG2     = 12,
  parameter int CFG_LOG2      = 20,
  parameter int SRAM_POP_LOG2 = 15,
  parameter int SRAM_RSV_LOG2 = 18,
  parameter int NAND_LOG2     = 20
) (
  input  logic [AW-1:0]           addr,
  input  logic [AW-1:0]           cfg_base,
  input  logic [NRNG-1:0][AW-1:0] rng_start,
  input  logic [NRNG-1:0][AW-1:0] rng_stop,
  input  logic [AW-1:0]           ddr_base,
  input  logic [AW-1:0]           ddr_attr,
  input  logic [AW-1:0]           sram_base,
  input  logic [AW-1:0]           nand_base,
  output logic [NWIN-1:0]         raw_hit,
  output logic                    sram_pop
);
  localparam logic [AW-1:0] CFG_M  = hi_mask(CFG_LOG2);
  localparam logic [AW-1:0] SRAM_M = hi_mask(SRAM_RSV_LOG2);
  localparam logic [AW-1:0] NAND_M = hi_mask(NAND_LOG2);

  assign raw_hit[W_CFG] = ((addr ^ cfg_base) & CFG_M) == '0;

  genvar g;
  generate
    for (g = 0; g < NRNG; g++) begin : g_rng
      logic [AW-PAGE_LOG2-1:0] page, lo, hi;
      assign page = addr[AW-1:PAGE_LOG2];
      assign lo   = rng_start[g][AW-1:PAGE_LOG2];
      assign hi   = rng_stop[g][AW-1:PAGE_LOG2];
      assign raw_hit[1+g] = rng_start[g][0] && (page >= lo) && (page <= hi);
    end
  endgenerate

  logic [4:0]    ddr_n;
  logic          ddr_legal;
  logic [AW-1:0] ddr_m;
  always_comb begin
    ddr_n     = ddr_attr[4:0];
    ddr_legal = (int'(ddr_n) >= DDR_N_MIN) && (int'(ddr_n) <= DDR_N_MAX);
    ddr_m     = hi_mask(int'(ddr_n) + 1);
  end
  assign raw_hit[W_DDR] = ddr_attr[AW-1] && ddr_legal && (((addr ^ ddr_base) & ddr_m) == '0);

  assign raw_hit[W_SRAM] = sram_base[0] && (((addr ^ sram_base) & SRAM_M) == '0);
  assign sram_pop        = addr[SRAM_RSV_LOG2-1:SRAM_POP_LOG2] == '0;
  assign raw_hit[W_NAND] = nand_base[0] && (((addr ^ nand_base) & NAND_M) == '0);

  logic unused_bits;
  assign unused_bits = ^{ddr_attr[AW-2:5]};
endmodule

// File: rtl/awd_select.sv
module awd_select
  import awd_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [AW-1:0]   addr,
  input  logic [NWIN-1:0] raw_hit,
  input  logic            sram_pop,
  output logic            out_valid,
  output logic [AW-1:0]   addr_out,
  output logic [NWIN-1:0] tgt_sel,
  output logic            hit,
  output logic            err,
  output logic            multi_hit
);
  logic [NWIN-1:0] first;
  logic            rsv;
  logic            many;

  always_comb begin
    first = raw_hit & (~raw_hit + NWIN'(1));
    rsv   = first[W_SRAM] && !sram_pop;
    many  = $countones(raw_hit) > 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      addr_out  <= '0;
      tgt_sel   <= '0;
      hit       <= 1'b0;
      err       <= 1'b0;
      multi_hit <= 1'b0;
    end else begin
      out_valid <= req_valid;
      addr_out  <= addr;
      if (req_valid) begin
        tgt_sel   <= rsv ? '0 : first;
        hit       <= (|first) && !rsv;
        err       <= rsv;
        multi_hit <= many;
      end else begin
        tgt_sel   <= '0;
        hit       <= 1'b0;
        err       <= 1'b0;
        multi_hit <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import awd_pkg::*;
#(
  parameter logic [31:0] CFG_RESET_BASE = 32'hFF40_0000,
  parameter int PAGE_LOG2     = 12,
  parameter int CFG_LOG2      = 20,
  parameter int SRAM_POP_LOG2 = 15,
  parameter int SRAM_RSV_LOG2 = 18,
  parameter int NAND_LOG2     = 20
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [5:0]  wr_idx,
  input  logic [31:0] wr_data,
  input  logic        req_valid,
  input  logic [31:0] addr_in,
  output logic        out_valid,
  output logic [31:0] addr_out,
  output logic [12:0] tgt_sel,
  output logic        hit,
  output logic        err,
  output logic        multi_hit
);
  logic [AW-1:0]           cfg_base, ddr_base, ddr_attr, sram_base, nand_base;
  logic [NRNG-1:0][AW-1:0] rng_start, rng_stop;
  logic [NWIN-1:0]         raw_hit;
  logic                    sram_pop;

  awd_regs #(.CFG_RESET_BASE(CFG_RESET_BASE)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cfg_base(cfg_base), .rng_start(rng_start), .rng_stop(rng_stop),
    .ddr_base(ddr_base), .ddr_attr(ddr_attr), .sram_base(sram_base),
    .nand_base(nand_base)
  );

  awd_match #(
    .PAGE_LOG2(PAGE_LOG2), .CFG_LOG2(CFG_LOG2), .SRAM_POP_LOG2(SRAM_POP_LOG2),
    .SRAM_RSV_LOG2(SRAM_RSV_LOG2), .NAND_LOG2(NAND_LOG2)
  ) u_match (
    .addr(addr_in), .cfg_base(cfg_base), .rng_start(rng_start),
    .rng_stop(rng_stop), .ddr_base(ddr_base), .ddr_attr(ddr_attr),
    .sram_base(sram_base), .nand_base(nand_base),
    .raw_hit(raw_hit), .sram_pop(sram_pop)
  );

  awd_select u_sel (
    .clk(clk), .rst(rst), .req_valid(req_valid), .addr(addr_in),
    .raw_hit(raw_hit), .sram_pop(sram_pop),
    .out_valid(out_valid), .addr_out(addr_out), .tgt_sel(tgt_sel),
    .hit(hit), .err(err), .multi_hit(multi_hit)
  );
endmodule

// File: rtl/awd_checker.sv
module awd_checker (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [31:0] addr_in,
  input logic        out_valid,
  input logic [31:0] addr_out,
  input logic [12:0] tgt_sel,
  input logic        hit,
  input logic        err,
  input logic        multi_hit
);
  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tgt_sel));

  p_valid_latency_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);

  p_passthru_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (addr_out == $past(addr_in)));

  p_hit_has_sel_r10: assert property (@(posedge clk) disable iff (rst)
    hit |-> $countones(tgt_sel) == 1);

  p_sel_needs_hit_r10: assert property (@(posedge clk) disable iff (rst)
    (tgt_sel != '0) |-> hit);

  p_err_excl_r7: assert property (@(posedge clk) disable iff (rst)
    err |-> (!hit && tgt_sel == '0));

  p_multi_valid_r9: assert property (@(posedge clk) disable iff (rst)
    multi_hit |-> out_valid);

  p_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!out_valid && !hit && !err && !multi_hit && tgt_sel == '0));
endmodule

bind addr_window_decoder awd_checker u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .addr_in(addr_in),
  .out_valid(out_valid), .addr_out(addr_out), .tgt_sel(tgt_sel),
  .hit(hit), .err(err), .multi_hit(multi_hit)
);

// File: tb/addr_window_decoder_tb.sv
module addr_window_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic [31:0] addr_in = '0;
  logic        out_valid, hit, err, multi_hit;
  logic [31:0] addr_out;
  logic [12:0] tgt_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] s_cfg, s_ddr, s_attr, s_sram, s_nand;
  logic [31:0] s_start [9];
  logic [31:0] s_stop  [9];

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_window_decoder u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .req_valid(req_valid), .addr_in(addr_in), .out_valid(out_valid),
    .addr_out(addr_out), .tgt_sel(tgt_sel), .hit(hit), .err(err),
    .multi_hit(multi_hit)
  );

  function automatic void shadow_reset();
    s_cfg = 32'hFF40_0000; s_ddr = '0; s_attr = '0; s_sram = '0; s_nand = '0;
    for (int k = 0; k < 9; k++) begin s_start[k] = '0; s_stop[k] = '0; end
  endfunction

  function automatic void shadow_write(input logic [5:0] idx, input logic [31:0] d);
    if (idx == 6'd0)  s_cfg  = d;
    if (idx == 6'd10) s_ddr  = d;
    if (idx == 6'd26) s_attr = d;
    if (idx == 6'd49) s_sram = d;
    if (idx == 6'd50) s_nand = d;
    for (int k = 0; k < 9; k++) begin
      if (int'(idx) == 1 + k)  s_start[k] = d;
      if (int'(idx) == 17 + k) s_stop[k]  = d;
    end
  endfunction

  // expected {out_valid, hit, err, multi_hit, tgt_sel, addr_out}
  function automatic logic [48:0] model(input logic v, input logic [31:0] a);
    logic [12:0] h;
    logic [12:0] sel;
    int          n, win, cnt;
    logic        e, hh, mm;
    h = '0;
    h[0] = a[31:20] == s_cfg[31:20];
    for (int k = 0; k < 9; k++)
      h[1+k] = s_start[k][0] && a[31:12] >= s_start[k][31:12] && a[31:12] <= s_stop[k][31:12];
    n = int'(s_attr[4:0]);
    if (s_attr[31] && n >= 11 && n <= 30)
      h[10] = (a >> (n+1)) == (s_ddr >> (n+1));
    h[11] = s_sram[0] && a[31:18] == s_sram[31:18];
    h[12] = s_nand[0] && a[31:20] == s_nand[31:20];
    win = -1; cnt = 0;
    for (int k = 12; k >= 0; k--) if (h[k]) begin win = k; cnt++; end
    sel = '0; e = 0; hh = 0; mm = 0;
    if (v) begin
      mm = cnt > 1;
      if (win == 11 && a[17:15] != 3'd0) e = 1;
      else if (win >= 0) begin hh = 1; sel[win] = 1'b1; end
    end
    return {v, hh, e, mm, sel, a};
  endfunction

  function automatic void compare(input string tag, input logic [48:0] exp);
    logic [48:0] got;
    got = {out_valid, hit, err, multi_hit, tgt_sel, addr_out};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got v=%b h=%b e=%b m=%b sel=%h a=%h exp v=%b h=%b e=%b m=%b sel=%h a=%h",
        tag, got[48], got[47], got[46], got[45], got[44:32], got[31:0],
        exp[48], exp[47], exp[46], exp[45], exp[44:32], exp[31:0]);
    end
  endfunction

  task automatic wr(input logic [5:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    shadow_write(idx, d);
  endtask

  task automatic acc(input string tag, input logic [31:0] a);
    logic [48:0] exp;
    @(negedge clk);
    req_valid = 1'b1; addr_in = a;
    exp = model(1'b1, a);
    @(negedge clk);
    compare(tag, exp);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    logic [48:0] exp;
    void'($urandom(32'd20240611));
    shadow_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state: outputs zero
    compare("R11 reset", 49'd0);

    // R3 configuration window at reset base
    acc("R3 cfg low", 32'hFF40_0000);
    acc("R3 cfg top", 32'hFF4F_FFFC);
    acc("R10 above cfg", 32'hFF50_0000);
    acc("R10 zero addr", 32'h0000_0000);
    wr(6'd0, 32'hE000_0000);
    acc("R3 moved cfg", 32'hE00A_BCD0);

    // R4 range window 3 (start idx 3, stop idx 19)
    wr(6'd3, 32'h1000_0001);
    wr(6'd19, 32'h1000_3000);
    acc("R4 start page", 32'h1000_0000);
    acc("R4 stop page end", 32'h1000_3FFF);
    acc("R4 past stop", 32'h1000_4000);
    acc("R4 below start", 32'h0FFF_FFFC);
    wr(6'd3, 32'h1000_0000);
    acc("R4 disabled", 32'h1000_1000);

    // R11 write in same cycle as access sees old value, next cycle new
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'd1; wr_data = 32'h5000_0001;
    req_valid = 1'b1; addr_in = 32'h5000_0000;
    exp = model(1'b1, 32'h5000_0000);
    shadow_write(6'd17, 32'h0000_0000);
    @(negedge clk);
    compare("R11 same-cycle old", exp);
    wr_en = 1'b0;
    shadow_write(6'd1, 32'h5000_0001);
    exp = model(1'b1, 32'h5000_0000);
    @(negedge clk);
    compare("R11 next-cycle new", exp);
    req_valid = 1'b0;
    wr(6'd17, 32'h5000_0000);
    acc("R4 single page", 32'h5000_0FF0);

    // R5 DDR window
    wr(6'd10, 32'h4000_0000);
    wr(6'd26, 32'h8000_001B);
    acc("R5 ddr base", 32'h4000_0000);
    acc("R5 ddr top", 32'h4FFF_FFFC);
    acc("R5 ddr past", 32'h5000_1000);
    wr(6'd26, 32'h8000_000A);
    acc("R5 illegal size", 32'h4000_0000);
    wr(6'd10, 32'h8000_0000);
    wr(6'd26, 32'h8000_001E);
    acc("R5 2GB window", 32'h9234_5678);
    acc("R9 cfg over ddr", 32'hE000_0010);

    // R6 R7 SRAM
    wr(6'd49, 32'h2000_0001);
    acc("R6 sram low", 32'h2000_0000);
    acc("R6 sram pop top", 32'h2000_7FFC);
    acc("R7 reserved start", 32'h2000_8000);
    acc("R7 reserved top", 32'h2003_FFFC);
    acc("R10 past sram", 32'h2004_0000);
    wr(6'd2, 32'h2000_0001);
    wr(6'd18, 32'h2000_F000);
    acc("R9 range over reserved", 32'h2000_8000);
    acc("R9 range over sram", 32'h2000_0100);

    // R8 NAND
    wr(6'd50, 32'h3000_0001);
    acc("R8 nand low", 32'h3000_0000);
    acc("R8 nand top", 32'h300F_FFFC);
    acc("R8 nand past", 32'h3010_0000);

    // R12 idle
    @(negedge clk);
    req_valid = 1'b0; addr_in = 32'h3000_0000;
    @(negedge clk);
    compare("R12 idle", 49'(32'h3000_0000));

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [5:0]  idx;
      logic [31:0] d, a;
      int          pick;
      pick = $urandom_range(0, 6);
      case (pick)
        0: idx = 6'd0;
        1: idx = 6'(1 + $urandom_range(0, 8));
        2: idx = 6'(17 + $urandom_range(0, 8));
        3: idx = 6'd10;
        4: idx = 6'd26;
        5: idx = 6'd49;
        default: idx = 6'd50;
      endcase
      d = $urandom;
      if (idx == 6'd26) d = {d[31], 26'd0, 5'($urandom_range(8, 31))};
      if (i % 3 == 0) wr(idx, d);
      case ($urandom_range(0, 4))
        0: a = $urandom;
        1: a = s_sram + 32'($urandom_range(0, 32'h3FFFF));
        2: a = s_start[$urandom_range(0, 8)] + 32'($urandom_range(0, 32'h3FFF));
        3: a = s_ddr ^ 32'($urandom_range(0, 32'hFFFFF));
        default: a = s_nand + 32'($urandom_range(0, 32'h1FFFFF));
      endcase
      acc("R9 random", a);
    end

    finish_run();
  end
endmodule